// File: doc/BRIEF.md
# Dual-Rail AND Word with Completion Detection

This block is one stage of a delay-insensitive datapath. It takes two operand words whose bits each travel on a pair of wires and forms their bitwise AND, also on wire pairs. A bit pair with both wires low is a spacer, meaning no data yet. The zero wire high carries logic 0. The one wire high carries logic 1. Every bit of the result is built from four state-holding C-element terms, one for each valid combination of the two operand bits. The term for "both operands one" drives the output one wire. The other three terms are ORed onto the output zero wire. For synthesis and simulation, each C-element is a flip-flop that is evaluated on every clock edge. A result bit therefore appears one cycle after both of its operand bits have arrived. It returns to spacer only one cycle after both operand bits have gone back to spacer.

A completion detector watches the result word. It raises one flag when every result pair carries data, and another flag when every result pair is back at spacer. A third flag reports any pair, on either operand or on the result, that shows the forbidden code with both wires high. Upstream logic is expected to separate successive data waves with a spacer wave.

Top module: `drAndWord`

## Requirements
- R1: Each bit pair is (one wire, zero wire). 00 is spacer, 01 (zero wire high) is logic 0, 10 (one wire high) is logic 1, and 11 is illegal.
- R2: Once both operand pairs of bit i carry data and are sampled at a clock edge, result pair i shows A_i AND B_i after that edge.
- R3: While either operand pair of bit i is still spacer, result pair i stays 00, whatever the other operand carries.
- R4: A result pair that carries data keeps its value while only one of its operand pairs has returned to spacer. It becomes 00 on the edge after both operand pairs have returned to spacer.
- R5: `wordDone` is high exactly when every result pair has exactly one wire high.
- R6: `wordNull` is high exactly when every result pair is 00.
- R7: `pairError` is high, with no clock delay, whenever any operand pair or any result pair is 11.
- R8: While `rstN` is low, every C-element is cleared: all result pairs are 00, `wordNull` is 1 and `wordDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that evaluates the C-element state bits |
| rstN | input | 1 | Active-low synchronous reset clearing every C-element |
| aOne | input | WIDTH | Operand A, one wires |
| aZero | input | WIDTH | Operand A, zero wires |
| bOne | input | WIDTH | Operand B, one wires |
| bZero | input | WIDTH | Operand B, zero wires |
| yOne | output | WIDTH | Result, one wires |
| yZero | output | WIDTH | Result, zero wires |
| wordDone | output | 1 | Every result pair carries data |
| wordNull | output | 1 | Every result pair is spacer |
| pairError | output | 1 | Some operand or result pair shows 11 |

## Verification
The bench drives operand bits so that they arrive and depart on skewed, random cycles. It checks the result word after every edge, bit by bit. This exposes a design that decodes with plain AND gates: such a design would drop a result bit to spacer as soon as either operand leaves, instead of holding it. It also exposes a design that emits a result before both operands have arrived. Directed steps hold one operand as data while the other stays spacer, and then the reverse, to confirm that the result neither fires early nor clears early. Other directed steps inject a 11 pair on an operand and then push one through to the result. A detector that watched only the operands, or only the result, would then leave `pairError` low.

// File: rtl/dr_and_pkg.sv
package dr_and_pkg;
  // Flags produced by the completion detector for the top level.
  typedef struct packed {
    logic wordDone;
    logic wordNull;
    logic pairError;
  } drFlags_t;
endpackage

// File: rtl/drCelem.sv
// One C-element modelled as a clocked state bit.
module drCelem (
  input  logic clk,
  input  logic rstN,
  input  logic inA,
  input  logic inB,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN)             q <= 1'b0;
    else if (inA && inB)   q <= 1'b1;
    else if (!inA && !inB) q <= 1'b0;
  end

  // R2: both inputs high sets the term
  a_r2_celem_rise: assert property (@(posedge clk) disable iff (!rstN)
    (inA && inB) |=> q);
  // R4: both inputs low clears the term
  a_r4_celem_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!inA && !inB) |=> !q);
  // R3: disagreeing inputs keep the term where it was
  a_r3_celem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inA != inB) |=> $stable(q));
endmodule

// File: rtl/drAndPath.sv
// Datapath: four decode C-elements per bit, merged onto the result wire pair.
module drAndPath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aOne,
  input  logic [WIDTH-1:0] aZero,
  input  logic [WIDTH-1:0] bOne,
  input  logic [WIDTH-1:0] bZero,
  output logic [WIDTH-1:0] yOne,
  output logic [WIDTH-1:0] yZero
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic t11, t10, t01, t00;

    drCelem u_t11 (.clk(clk), .rstN(rstN), .inA(aOne[i]),  .inB(bOne[i]),  .q(t11));
    drCelem u_t10 (.clk(clk), .rstN(rstN), .inA(aOne[i]),  .inB(bZero[i]), .q(t10));
    drCelem u_t01 (.clk(clk), .rstN(rstN), .inA(aZero[i]), .inB(bOne[i]),  .q(t01));
    drCelem u_t00 (.clk(clk), .rstN(rstN), .inA(aZero[i]), .inB(bZero[i]), .q(t00));

    assign yOne[i]  = t11;
    assign yZero[i] = t10 | t01 | t00;

    // R4: a result pair only falls to spacer after both operands were spacer
    a_r4_spacer_after_both: assert property (@(posedge clk) disable iff (!rstN)
      ($past(yOne[i] | yZero[i]) && !(yOne[i] | yZero[i]))
        |-> $past(!aOne[i] && !aZero[i] && !bOne[i] && !bZero[i]));
    // R2: two ones on the inputs give a one on the result
    a_r2_and_one: assert property (@(posedge clk) disable iff (!rstN)
      $past(aOne[i] && bOne[i]) |-> yOne[i]);
    // R3: a spacer operand keeps a spacer result at spacer
    a_r3_no_early_output: assert property (@(posedge clk) disable iff (!rstN)
      $past(!(yOne[i] | yZero[i]) && !aOne[i] && !aZero[i]) |-> !(yOne[i] | yZero[i]));
  end
endmodule

// File: rtl/drDetect.sv
// Control side: completion, spacer and illegal-code detection.
module drDetect
  import dr_and_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aOne,
  input  logic [WIDTH-1:0] aZero,
  input  logic [WIDTH-1:0] bOne,
  input  logic [WIDTH-1:0] bZero,
  input  logic [WIDTH-1:0] yOne,
  input  logic [WIDTH-1:0] yZero,
  output drFlags_t         flags
);
  logic [WIDTH-1:0] illegalBits;

  always_comb begin
    illegalBits     = (aOne & aZero) | (bOne & bZero) | (yOne & yZero);
    flags.wordDone  = &(yOne ^ yZero);
    flags.wordNull  = ~|(yOne | yZero);
    flags.pairError = |illegalBits;
  end

  // R5/R6: a word cannot be both complete and empty
  a_r5_done_null_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(flags.wordDone && flags.wordNull));
  // R6: after a cycle with both operands fully spacer, the result word is null
  a_r6_null_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(~|(aOne | aZero | bOne | bZero)) |-> flags.wordNull);
endmodule

// File: rtl/drAndWord.sv
// Thin top: dual-rail AND datapath plus completion detector.
module drAndWord
  import dr_and_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aOne,
  input  logic [WIDTH-1:0] aZero,
  input  logic [WIDTH-1:0] bOne,
  input  logic [WIDTH-1:0] bZero,
  output logic [WIDTH-1:0] yOne,
  output logic [WIDTH-1:0] yZero,
  output logic             wordDone,
  output logic             wordNull,
  output logic             pairError
);
  drFlags_t flags;

  drAndPath #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN),
    .aOne(aOne), .aZero(aZero), .bOne(bOne), .bZero(bZero),
    .yOne(yOne), .yZero(yZero)
  );

  drDetect #(.WIDTH(WIDTH)) u_detect (
    .clk(clk), .rstN(rstN),
    .aOne(aOne), .aZero(aZero), .bOne(bOne), .bZero(bZero),
    .yOne(yOne), .yZero(yZero),
    .flags(flags)
  );

  assign wordDone  = flags.wordDone;
  assign wordNull  = flags.wordNull;
  assign pairError = flags.pairError;
endmodule

// File: tb/drAndWord_tb.sv
module drAndWord_tb;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC_A [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A,
                                          32'hFFFF_0000, 32'h1234_5678, 32'h8000_0001};
  localparam logic [W-1:0] VEC_B [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0F0F_F0F0,
                                          32'h00FF_FF00, 32'hFEDC_BA98, 32'h8000_0001};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aOne = '0, aZero = '0, bOne = '0, bZero = '0;
  logic [W-1:0] yOne, yZero;
  logic wordDone, wordNull, pairError;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drAndWord #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aOne(aOne), .aZero(aZero), .bOne(bOne), .bZero(bZero),
    .yOne(yOne), .yZero(yZero),
    .wordDone(wordDone), .wordNull(wordNull), .pairError(pairError)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkY(input string req, input logic [W-1:0] eOne, input logic [W-1:0] eZero);
    check({yOne, yZero} === {eOne, eZero}, req, {yOne, yZero}, {eOne, eZero});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Data wave with random per-bit arrival, checking R2, R3 and R5 each cycle
  task automatic dataWave(input logic [W-1:0] a, input logic [W-1:0] b);
    int aT[W];
    int bT[W];
    logic [W-1:0] ready;
    logic [W-1:0] r = a & b;
    for (int i = 0; i < W; i++) begin
      aT[i] = int'($urandom_range(0, 3));
      bT[i] = int'($urandom_range(0, 3));
    end
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < W; i++) begin
        if (aT[i] <= s) begin aOne[i] = a[i]; aZero[i] = ~a[i]; end
        if (bT[i] <= s) begin bOne[i] = b[i]; bZero[i] = ~b[i]; end
      end
      tick();
      for (int i = 0; i < W; i++) ready[i] = (aT[i] <= s) && (bT[i] <= s);
      checkY("R2/R3 skewed arrival", ready & r, ready & ~r);
      check(wordDone == (&ready), "R5 wordDone", {63'd0, wordDone}, {63'd0, &ready});
    end
  endtask

  // Spacer wave with random per-bit departure, checking R4 and R6 each cycle
  task automatic spacerWave(input logic [W-1:0] a, input logic [W-1:0] b);
    int aT[W];
    int bT[W];
    logic [W-1:0] live;
    logic [W-1:0] r = a & b;
    for (int i = 0; i < W; i++) begin
      aT[i] = int'($urandom_range(0, 3));
      bT[i] = int'($urandom_range(0, 3));
    end
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < W; i++) begin
        if (aT[i] <= s) begin aOne[i] = 1'b0; aZero[i] = 1'b0; end
        if (bT[i] <= s) begin bOne[i] = 1'b0; bZero[i] = 1'b0; end
      end
      tick();
      for (int i = 0; i < W; i++) live[i] = !((aT[i] <= s) && (bT[i] <= s));
      checkY("R4 skewed spacer", live & r, live & ~r);
      check(wordNull == ~(|live), "R6 wordNull", {63'd0, wordNull}, {63'd0, ~(|live)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) tick();
    checkY("R8 reset outputs", '0, '0);
    check(wordNull && !wordDone && !pairError, "R8 reset flags",
          {61'd0, wordDone, wordNull, pairError}, 64'd2);
    rstN = 1'b1;
    tick();

    // Vector table walk: R1 encoding, R2..R6
    for (int v = 0; v < NV; v++) begin
      dataWave(VEC_A[v], VEC_B[v]);
      spacerWave(VEC_A[v], VEC_B[v]);
    end

    // R3: A data, B still spacer, result stays spacer
    aOne = 32'hF0F0_F0F0; aZero = ~aOne;
    repeat (3) begin
      tick();
      checkY("R3 A only", '0, '0);
    end
    // R3 reverse: drop A, hold B data
    aOne = '0; aZero = '0; tick();
    bOne = 32'h3333_3333; bZero = ~bOne;
    tick();
    checkY("R3 B only", '0, '0);
    // R2: A arrives, result after one edge
    aOne = 32'hFFFF_0000; aZero = ~aOne;
    tick();
    checkY("R2 directed", 32'h3333_0000, ~32'h3333_0000);
    // R4: A returns, B holds; result holds
    aOne = '0; aZero = '0;
    repeat (2) begin
      tick();
      checkY("R4 hold on one spacer", 32'h3333_0000, ~32'h3333_0000);
    end
    bOne = '0; bZero = '0;
    tick();
    checkY("R4 cleared after both", '0, '0);

    // R7: illegal code on an input, no clock delay
    aOne[3] = 1'b1; aZero[3] = 1'b1;
    #1;
    check(pairError === 1'b1, "R7 input 11", {63'd0, pairError}, 64'd1);
    aOne = '0; aZero = '0;
    #1;
    check(pairError === 1'b0, "R7 error clears", {63'd0, pairError}, 64'd0);
    // R7: illegal code pushed through to the result
    tick();
    aOne[5] = 1'b1; aZero[5] = 1'b1; bOne[5] = 1'b1; bZero[5] = 1'b1;
    tick();
    aOne = '0; aZero = '0; bOne = '0; bZero = '0;
    #1;
    check(pairError === 1'b1 && yOne[5] && yZero[5], "R7 output 11",
          {62'd0, yOne[5] & yZero[5], pairError}, 64'd3);
    tick();
    check(!pairError && wordNull, "R7 output recovers",
          {62'd0, wordNull, pairError}, 64'd2);

    // R8: reset clears held data
    aOne = '1; aZero = '0; bOne = '1; bZero = '0;
    tick();
    rstN = 1'b0;
    tick();
    checkY("R8 reset clears data", '0, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule